// File: doc/BRIEF.md
# Four-Channel DMA Control Register Group

This block holds the control-side state of a four-channel DMA controller: a command register, one mode register per channel, a per-channel mask, per-channel request bits and per-channel terminal-count flags. A host reaches it through a byte-wide register bus that decodes offsets 8 to 15 of a 16-entry window. Peripherals raise and drop their channel requests through hold and release pulses. The transfer engine reports the end of a block through terminal-count pulses. The block works out which channels may be served and grants the lowest-numbered one.

Address counters, byte counters and the memory transfers are handled by neighbouring logic. This block signals that logic in two ways. It sends a one-cycle pulse when the shared byte-pointer flip-flop must be cleared. It also shows the command value and the mode byte of the granted channel.

Reads are registered: read data appears the cycle after the read strobe. Any clear-on-read side effect takes hold at the same clock edge.

Top module: `dma_ctl_top`

## Requirements
- R1: A write to offset 8 loads the command register only when the data is 0x00 or 0x04, that is, no bit other than bit 2 is set. Any other value leaves `cmdValue` unchanged. The new value shows on `cmdValue` after the write edge.
- R2: A write to offset 9 takes the channel from data bits [1:0]. Data bit 2 set makes that channel's request bit (status bit channel+4) one, and bit 2 clear makes it zero. In both cases the write clears that channel's terminal-count flag (status bit channel).
- R3: A write to offset 10 takes the channel from data bits [1:0]. It sets that channel's mask bit when data bit 2 is 1 and clears it when data bit 2 is 0. The other mask bits are unchanged.
- R4: A write to offset 11 stores the whole byte as the mode of the channel in data bits [1:0]. `grantMode` shows the mode byte of the granted channel, and shows 0x00 when no channel is granted.
- R5: A write to offset 12 makes `ffClear` high for exactly the one cycle after the write edge. Otherwise `ffClear` is low, except after a write to offset 13 (R7).
- R6: A write to offset 14 clears all mask bits, whatever the data. A write to offset 15 loads the mask from data bits [3:0].
- R7: A write to offset 13 is a master reset. It pulses `ffClear` for one cycle, sets all four mask bits, zeroes all request and terminal-count bits, and zeroes the command register. Mode registers are kept.
- R8: A read returns its data on `regRdData` the cycle after `regRdEn`. At offset 8 the read returns the status byte: request bits in [7:4], terminal-count flags in [3:0]. The same edge clears the terminal-count flags and keeps the request bits. At offset 15 the read returns {4'b0, mask}. At every other offset the read returns 0x00.
- R9: A pulse on `dreqHold[i]` sets the request bit of channel i. A pulse on `dreqRelease[i]` clears it. These external pulses win over a request write to the same channel in the same cycle.
- R10: A pulse on `tcPulse[i]` sets the terminal-count flag of channel i. The flag stays set until a status read (R8), a request write to channel i (R2) or a master reset (R7).
- R11: A channel is eligible when its mask bit is 0 and its request bit is 1. `serviceReq` is high exactly when at least one channel is eligible.
- R12: `grant` is one-hot or zero. Its bit i is set for the lowest-numbered eligible channel, scanning from channel 0 up to channel 3.
- R13: After `rstN` is asserted low, the block holds the master-reset state: mask 0xF, status 0x00, command 0x00. In addition `ffClear` is low, `regRdData` is 0x00 and every mode register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Register offset; 8 to 15 are decoded |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Registered read data |
| dreqHold | input | 4 | Per-channel request set pulses |
| dreqRelease | input | 4 | Per-channel request clear pulses |
| tcPulse | input | 4 | Per-channel terminal-count pulses |
| ffClear | output | 1 | One-cycle byte-pointer flip-flop clear |
| serviceReq | output | 1 | At least one channel is eligible |
| grant | output | 4 | One-hot grant to the lowest eligible channel |
| grantMode | output | 8 | Mode byte of the granted channel |
| cmdValue | output | 8 | Current command register |

## Verification
A corrupt mask bit or request bit shows at once on `grant` and `serviceReq`, in the same cycle as the bad state, because arbitration is combinational. A wrong terminal-count flag or a faulty clear-on-read is only visible through a status read, one cycle after the read strobe. So the bench reads status twice in a row to catch a flag that was not cleared. A wrongly accepted or wrongly rejected command shows on `cmdValue` right after the write edge. A mode byte that went to the wrong channel shows only once that channel holds the grant, so the bench moves the grant between channels on purpose.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  // Offsets within the 16-entry register window
  localparam logic [3:0] OFS_STAT_CMD = 4'd8;
  localparam logic [3:0] OFS_REQUEST  = 4'd9;
  localparam logic [3:0] OFS_MASK_ONE = 4'd10;
  localparam logic [3:0] OFS_MODE     = 4'd11;
  localparam logic [3:0] OFS_FF_CLR   = 4'd12;
  localparam logic [3:0] OFS_MASTER   = 4'd13;
  localparam logic [3:0] OFS_MASK_CLR = 4'd14;
  localparam logic [3:0] OFS_MASK_ALL = 4'd15;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic cmdLoad;
    logic reqWr;
    logic maskOne;
    logic modeWr;
    logic ffClr;
    logic masterRst;
    logic maskClrAll;
    logic maskLoad;
    logic statusRd;
    logic maskRd;
    logic anyRd;
  } ctlStrobes_t;

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [DATA_W-1:0] CMD_OK_MASK = 8'h04
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output ctlStrobes_t       strobes
);

  logic cmdAcceptable;
  logic [3:0] ofs;

  assign ofs = 4'(regAddr);
  assign cmdAcceptable = ((regWrData & ~CMD_OK_MASK) == '0);

  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      case (ofs)
        OFS_STAT_CMD: strobes.cmdLoad    = cmdAcceptable;
        OFS_REQUEST:  strobes.reqWr      = 1'b1;
        OFS_MASK_ONE: strobes.maskOne    = 1'b1;
        OFS_MODE:     strobes.modeWr     = 1'b1;
        OFS_FF_CLR:   strobes.ffClr      = 1'b1;
        OFS_MASTER:   strobes.masterRst  = 1'b1;
        OFS_MASK_CLR: strobes.maskClrAll = 1'b1;
        OFS_MASK_ALL: strobes.maskLoad   = 1'b1;
        default: ;
      endcase
    end
    if (regRdEn) begin
      strobes.anyRd    = 1'b1;
      strobes.statusRd = (ofs == OFS_STAT_CMD);
      strobes.maskRd   = (ofs == OFS_MASK_ALL);
    end
  end

endmodule

// File: rtl/dma_ctl_regfile.sv
module dma_ctl_regfile
  import dma_ctl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobes_t                    strobes,
  input  logic [DATA_W-1:0]              regWrData,
  input  logic [NUM_CH-1:0]              dreqHold,
  input  logic [NUM_CH-1:0]              dreqRelease,
  input  logic [NUM_CH-1:0]              tcPulse,
  output logic [DATA_W-1:0]              cmdValue,
  output logic [NUM_CH-1:0]              maskBits,
  output logic [NUM_CH-1:0]              reqBits,
  output logic [NUM_CH-1:0][DATA_W-1:0]  modeRegs,
  output logic [DATA_W-1:0]              regRdData,
  output logic                           ffClear
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] tcBits;
  logic [NUM_CH-1:0] reqNext, tcNext, maskNext;
  logic [DATA_W-1:0] cmdNext, statusByte, rdNext;
  logic [CH_W-1:0]   chSel;
  logic              setBit;

  assign chSel      = regWrData[CH_W-1:0];
  assign setBit     = regWrData[CH_W];
  assign statusByte = DATA_W'({reqBits, tcBits});

  always_comb begin
    reqNext  = reqBits;
    tcNext   = strobes.statusRd ? '0 : tcBits;
    maskNext = maskBits;
    cmdNext  = cmdValue;

    if (strobes.reqWr) begin
      reqNext[chSel] = setBit;
      tcNext[chSel]  = 1'b0;
    end
    reqNext = (reqNext & ~dreqRelease) | dreqHold;
    tcNext  = tcNext | tcPulse;

    if (strobes.maskOne)    maskNext[chSel] = setBit;
    if (strobes.maskClrAll) maskNext = '0;
    if (strobes.maskLoad)   maskNext = regWrData[NUM_CH-1:0];
    if (strobes.cmdLoad)    cmdNext  = regWrData;

    if (strobes.masterRst) begin
      reqNext  = '0;
      tcNext   = '0;
      maskNext = '1;
      cmdNext  = '0;
    end

    if (strobes.statusRd)    rdNext = statusByte;
    else if (strobes.maskRd) rdNext = DATA_W'(maskBits);
    else                     rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBits   <= '0;
      tcBits    <= '0;
      maskBits  <= '1;
      cmdValue  <= '0;
      ffClear   <= 1'b0;
      regRdData <= '0;
    end else begin
      reqBits  <= reqNext;
      tcBits   <= tcNext;
      maskBits <= maskNext;
      cmdValue <= cmdNext;
      ffClear  <= strobes.ffClr | strobes.masterRst;
      if (strobes.anyRd) regRdData <= rdNext;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gModeReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeRegs[ch] <= '0;
      end else if (strobes.modeWr && (chSel == CH_W'(ch))) begin
        modeRegs[ch] <= regWrData;
      end
    end
  end

endmodule

// File: rtl/dma_ctl_arbiter.sv
module dma_ctl_arbiter #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] eligible,
  output logic [NUM_CH-1:0] grant,
  output logic              anyEligible
);

  logic [NUM_CH:0] seenLower;

  assign seenLower[0] = 1'b0;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gScan
    assign grant[ch]         = eligible[ch] & ~seenLower[ch];
    assign seenLower[ch + 1] = seenLower[ch] | eligible[ch];
  end

  assign anyEligible = seenLower[NUM_CH];

endmodule

// File: rtl/dma_ctl_top.sv
module dma_ctl_top
  import dma_ctl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_CH-1:0] dreqHold,
  input  logic [NUM_CH-1:0] dreqRelease,
  input  logic [NUM_CH-1:0] tcPulse,
  output logic              ffClear,
  output logic              serviceReq,
  output logic [NUM_CH-1:0] grant,
  output logic [DATA_W-1:0] grantMode,
  output logic [DATA_W-1:0] cmdValue
);

  ctlStrobes_t                   strobes;
  logic [NUM_CH-1:0]             maskBits, reqBits, eligible;
  logic [NUM_CH-1:0][DATA_W-1:0] modeRegs;

  dma_ctl_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDecode (
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobes   (strobes)
  );

  dma_ctl_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regWrData   (regWrData),
    .dreqHold    (dreqHold),
    .dreqRelease (dreqRelease),
    .tcPulse     (tcPulse),
    .cmdValue    (cmdValue),
    .maskBits    (maskBits),
    .reqBits     (reqBits),
    .modeRegs    (modeRegs),
    .regRdData   (regRdData),
    .ffClear     (ffClear)
  );

  assign eligible = reqBits & ~maskBits;

  dma_ctl_arbiter #(.NUM_CH(NUM_CH)) uArb (
    .eligible    (eligible),
    .grant       (grant),
    .anyEligible (serviceReq)
  );

  always_comb begin
    grantMode = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      grantMode = grantMode | (modeRegs[ch] & {DATA_W{grant[ch]}});
    end
  end

endmodule

// File: rtl/dma_ctl_checker.sv
module dma_ctl_checker #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              ffClear,
  input logic              serviceReq,
  input logic [NUM_CH-1:0] grant,
  input logic [DATA_W-1:0] grantMode,
  input logic [DATA_W-1:0] cmdValue
);

  p_grant_onehot_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  p_svc_match_r11: assert property (@(posedge clk) disable iff (!rstN)
    serviceReq == (grant != '0));

  p_cmd_reject_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 4'd8 && (regWrData & 8'hFB) != 8'h00) |=> $stable(cmdValue));

  p_cmd_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 4'd8 && (regWrData & 8'hFB) == 8'h00) |=> cmdValue == $past(regWrData));

  p_ffclr_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 4'd12) |=> ffClear);

  p_ffclr_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && (regAddr == 4'd12 || regAddr == 4'd13)) |=> !ffClear);

  p_master_rst_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 4'd13) |=> (!serviceReq && cmdValue == 8'h00 && ffClear));

  p_rd_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr != 4'd8 && regAddr != 4'd15) |=> regRdData == 8'h00);

  p_mode_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !serviceReq |-> grantMode == 8'h00);

endmodule

bind dma_ctl_top dma_ctl_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_dma_ctl_top.sv
module tb_dma_ctl_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic [3:0] dreqHold = 4'd0;
  logic [3:0] dreqRelease = 4'd0;
  logic [3:0] tcPulse = 4'd0;
  logic       ffClear;
  logic       serviceReq;
  logic [3:0] grant;
  logic [7:0] grantMode;
  logic [7:0] cmdValue;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_ctl_top dut (.*);

  // Vector: {op[1:0], addr[3:0], data[7:0], expect[7:0]}
  // op 0 = write, 1 = read and compare, 2 = compare cmdValue
  localparam int NV = 30;
  localparam logic [21:0] VECS [NV] = '{
    {2'd1, 4'd8,  8'h00, 8'h00},  // R13 status after reset
    {2'd1, 4'd15, 8'h00, 8'h0F},  // R13 mask after reset
    {2'd1, 4'd3,  8'h00, 8'h00},  // R8 undecoded offset
    {2'd1, 4'd12, 8'h00, 8'h00},  // R8 write-only offset
    {2'd0, 4'd8,  8'h04, 8'h00},
    {2'd2, 4'd0,  8'h00, 8'h04},  // R1 accepted
    {2'd0, 4'd8,  8'h01, 8'h00},
    {2'd2, 4'd0,  8'h00, 8'h04},  // R1 rejected
    {2'd0, 4'd8,  8'h00, 8'h00},
    {2'd2, 4'd0,  8'h00, 8'h00},  // R1 zero accepted
    {2'd0, 4'd8,  8'h44, 8'h00},
    {2'd2, 4'd0,  8'h00, 8'h00},  // R1 rejected
    {2'd0, 4'd8,  8'h04, 8'h00},
    {2'd2, 4'd0,  8'h00, 8'h04},  // R1
    {2'd0, 4'd14, 8'hA5, 8'h00},
    {2'd1, 4'd15, 8'h00, 8'h00},  // R6 clear all
    {2'd0, 4'd15, 8'h0A, 8'h00},
    {2'd1, 4'd15, 8'h00, 8'h0A},  // R6 load
    {2'd0, 4'd10, 8'h04, 8'h00},
    {2'd1, 4'd15, 8'h00, 8'h0B},  // R3 set ch0
    {2'd0, 4'd10, 8'h03, 8'h00},
    {2'd1, 4'd15, 8'h00, 8'h03},  // R3 clear ch3
    {2'd0, 4'd9,  8'h06, 8'h00},
    {2'd1, 4'd8,  8'h00, 8'h40},  // R2 set req ch2
    {2'd1, 4'd8,  8'h00, 8'h40},  // R8 request bits kept
    {2'd0, 4'd9,  8'h02, 8'h00},
    {2'd1, 4'd8,  8'h00, 8'h00},  // R2 clear req ch2
    {2'd0, 4'd10, 8'h01, 8'h00},
    {2'd1, 4'd15, 8'h00, 8'h01},  // R3 clear ch1
    {2'd0, 4'd15, 8'h0F, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic pulseLines(input logic [3:0] hold, input logic [3:0] rel, input logic [3:0] tc);
    @(negedge clk);
    dreqHold = hold; dreqRelease = rel; tcPulse = tc;
    @(negedge clk);
    dreqHold = '0; dreqRelease = '0; tcPulse = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R13 cmdValue", cmdValue, 8'h00);
    check("R13 ffClear", ffClear, 1'b0);
    check("R13 grant", grant, 4'h0);
    check("R13 regRdData", regRdData, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] a;
      logic [7:0] d, e;
      {op, a, d, e} = VECS[i];
      case (op)
        2'd0: doWrite(a, d);
        2'd1: begin
          doRead(a, rd);
          check($sformatf("R8 vector %0d read", i), rd, e);
        end
        default: check($sformatf("R1 vector %0d cmd", i), cmdValue, e);
      endcase
    end

    // R12 / R11: arbitration
    doWrite(4'd15, 8'h00);
    check("R11 idle", serviceReq, 1'b0);
    pulseLines(4'b1100, 4'b0000, 4'b0000);
    check("R12 lowest ch2", grant, 4'b0100);
    check("R11 serviceReq", serviceReq, 1'b1);
    doWrite(4'd10, 8'h06);  // mask ch2
    check("R11 masked ch2 skipped", grant, 4'b1000);
    doWrite(4'd9, 8'h05);   // request ch1
    check("R12 ch1 wins", grant, 4'b0010);
    pulseLines(4'b0001, 4'b0000, 4'b0000);
    check("R12 ch0 wins", grant, 4'b0001);

    // R4: modes follow the grant
    doWrite(4'd11, 8'h61);  // ch1 mode
    doWrite(4'd11, 8'h94);  // ch0 mode
    check("R4 ch0 mode", grantMode, 8'h94);
    pulseLines(4'b0000, 4'b0001, 4'b0000);
    check("R9 release ch0", grant, 4'b0010);
    check("R4 ch1 mode", grantMode, 8'h61);

    // R9: hold wins over request clear in the same cycle
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd9; regWrData = 8'h01; dreqHold = 4'b0010;
    @(negedge clk);
    regWrEn = 1'b0; dreqHold = 4'b0000;
    check("R9 hold beats request write", grant, 4'b0010);
    pulseLines(4'b0000, 4'b1111, 4'b0000);
    check("R9 release all", serviceReq, 1'b0);
    doRead(4'd8, rd);
    check("R9 status empty", rd, 8'h00);

    // R10: terminal-count flags
    pulseLines(4'b0000, 4'b0000, 4'b1000);
    doRead(4'd8, rd);
    check("R10 tc ch3 set", rd, 8'h08);
    doRead(4'd8, rd);
    check("R8 tc cleared by read", rd, 8'h00);
    pulseLines(4'b0100, 4'b0000, 4'b0010);
    doWrite(4'd9, 8'h01);   // clear req ch1, clears tc ch1
    doRead(4'd8, rd);
    check("R2 tc cleared by request write", rd, 8'h40);

    // R5: flip-flop clear pulse
    doWrite(4'd12, 8'h00);
    check("R5 ffClear high", ffClear, 1'b1);
    @(negedge clk);
    check("R5 ffClear one cycle", ffClear, 1'b0);

    // R7: master reset
    doWrite(4'd8, 8'h04);
    doWrite(4'd14, 8'h00);
    pulseLines(4'b0001, 4'b0000, 4'b0100);
    check("R7 setup grant", grant, 4'b0001);
    doWrite(4'd13, 8'h00);
    check("R7 ffClear", ffClear, 1'b1);
    check("R7 cmd zero", cmdValue, 8'h00);
    check("R7 no service", serviceReq, 1'b0);
    doRead(4'd15, rd);
    check("R7 mask set", rd, 8'h0F);
    doRead(4'd8, rd);
    check("R7 status zero", rd, 8'h00);
    doWrite(4'd15, 8'h00);
    pulseLines(4'b0001, 4'b0000, 4'b0000);
    check("R7 mode kept", grantMode, 8'h94);

    // R13: hardware reset in mid-run
    doWrite(4'd8, 8'h04);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R13 grant after reset", grant, 4'h0);
    check("R13 cmd after reset", cmdValue, 8'h00);
    doRead(4'd15, rd);
    check("R13 mask after reset", rd, 8'h0F);
    doWrite(4'd15, 8'h00);
    pulseLines(4'b0001, 4'b0000, 4'b0000);
    check("R13 mode cleared", grantMode, 8'h00);
    check("R13 grant ch0", grant, 4'b0001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule